// File: doc/BRIEF.md
# Page Translation Lookaside Cache

This block holds recently used page translations for an I/O address translation unit. Each incoming access presents a 32-bit I/O virtual address. The upper bits form a 4 KiB page number, which is compared in parallel against every stored entry. On a hit the block returns, in the same cycle, the physical page number joined to the untouched low 12 offset bits, together with the read and write permissions of that page. On a miss it raises a fill request that carries the page number, and it keeps the access waiting until the external table walker returns the page-table word for that page.

Stale translations are removed in three ways. A single-line shootdown takes an I/O virtual address and drops only the entry for that page. A flush strobe drops every entry at once. A fault-retire strobe also drops every entry, so no translation survives a page fault. When paging is switched off, the block is bypassed: addresses pass straight through and the stored entries are left untouched. Replacement is round-robin over a parameterised number of entries, which defaults to 8.

Top module: `xlc_cache`

## Requirements
- R1: After reset no entry is valid. A lookup with paging enabled misses, drives `fill_req` high and puts the lookup's page number (address bits 31:12) on `fill_req_vpn`.
- R2: When a lookup with paging enabled hits, `lk_hit` is high in the same cycle and `lk_paddr` is the cached physical page number in bits 31:12, with lookup address bits 11:0 copied unchanged into bits 11:0.
- R3: A missed lookup keeps `lk_hit` low and `fill_req` high for as long as it is held. A fill accepted on a clock edge makes the held lookup hit in the following cycle.
- R4: A fill takes its physical page number from bits 31:12 of `fill_pte`, the read permission from bit 1 and the write permission from bit 2. The entry reports these permissions on `lk_rd_ok` and `lk_wr_ok`.
- R5: A fill for a page number that is not present writes the entry selected by a round-robin pointer. The pointer starts at entry 0 after reset and advances by one after each such allocation. With 8 entries, the ninth distinct page evicts the first one.
- R6: A fill for a page number that is already present overwrites that same entry and does not advance the round-robin pointer.
- R7: A single-line shootdown (`zap_line_valid` with `zap_line_iova`) invalidates only the entry whose page number equals bits 31:12 of the address. Bits 11:0 are ignored and all other entries keep hitting.
- R8: `zap_all` invalidates every entry on the next clock edge.
- R9: `fault_done` invalidates every entry on the next clock edge.
- R10: If a single-line shootdown of the same page, or `zap_all`, or `fault_done` arrives in the same cycle as a fill, the filled entry is left invalid.
- R11: With `paging_en` low, a valid lookup reports a hit with `lk_paddr` equal to `lk_iova`, both permissions set and no fill request. The cache contents are unchanged, so entries still hit once paging is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| paging_en | input | 1 | Translation enabled; low selects bypass |
| lk_valid | input | 1 | Lookup request present |
| lk_iova | input | VA_W | Lookup I/O virtual address |
| lk_hit | output | 1 | Lookup done this cycle (hit or bypass) |
| lk_paddr | output | VA_W | Translated physical address |
| lk_rd_ok | output | 1 | Page readable |
| lk_wr_ok | output | 1 | Page writable |
| fill_req | output | 1 | Miss; walker asked for a translation |
| fill_req_vpn | output | VA_W-PAGE_BITS | Page number that missed |
| fill_valid | input | 1 | Walker result present |
| fill_vpn | input | VA_W-PAGE_BITS | Page number of the walker result |
| fill_pte | input | VA_W | Page-table word: page [31:12], write [2], read [1] |
| zap_line_valid | input | 1 | Single-line shootdown strobe |
| zap_line_iova | input | VA_W | Address whose page is shot down |
| zap_all | input | 1 | Flush every entry |
| fault_done | input | 1 | Page fault retired; flush every entry |

## Verification
Directed sequences fill the cache to capacity and then refill a present page before adding a new one. Whether the oldest page or the refilled page is evicted shows whether in-place update and the round-robin pointer behave correctly. Shootdowns with nonzero offset bits check that only the page number is compared. Shootdowns and flushes issued in the same cycle as a fill check that invalidation takes priority. Random stimulus then draws page numbers from a small pool, so hits, evictions, refills and collisions between a shootdown and a fill all occur often, and every lookup is compared against a bench model of the entry array.

// File: rtl/xlc_pkg.sv
package xlc_pkg;
   // Permission bit positions inside a page-table word returned by the walker
   localparam int PTE_RD_BIT = 1;
   localparam int PTE_WR_BIT = 2;

   typedef struct packed {
      logic rd;
      logic wr;
   } xlc_perm_t;
endpackage

// File: rtl/xlc_match.sv
module xlc_match #(
   parameter int ENTRIES = 8,
   parameter int TAG_W   = 20,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic [ENTRIES-1:0] valid,
   input  logic [TAG_W-1:0]   tags [ENTRIES],
   input  logic [TAG_W-1:0]   key,
   output logic [ENTRIES-1:0] hit_vec,
   output logic               hit_any,
   output logic [IDX_W-1:0]   hit_idx
);
   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      assign hit_vec[e] = valid[e] && (tags[e] == key);
   end

   assign hit_any = |hit_vec;

   always_comb begin
      hit_idx = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (hit_vec[i]) hit_idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/xlc_victim.sv
module xlc_victim #(
   parameter int ENTRIES = 8,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance,
   output logic [IDX_W-1:0] ptr
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ptr <= '0;
      else if (advance)  ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
   end
endmodule

// File: rtl/xlc_cache.sv
module xlc_cache #(
   parameter int VA_W      = 32,
   parameter int PAGE_BITS = 12,
   parameter int ENTRIES   = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      paging_en,
   input  logic                      lk_valid,
   input  logic [VA_W-1:0]           lk_iova,
   output logic                      lk_hit,
   output logic [VA_W-1:0]           lk_paddr,
   output logic                      lk_rd_ok,
   output logic                      lk_wr_ok,
   output logic                      fill_req,
   output logic [VA_W-PAGE_BITS-1:0] fill_req_vpn,
   input  logic                      fill_valid,
   input  logic [VA_W-PAGE_BITS-1:0] fill_vpn,
   input  logic [VA_W-1:0]           fill_pte,
   input  logic                      zap_line_valid,
   input  logic [VA_W-1:0]           zap_line_iova,
   input  logic                      zap_all,
   input  logic                      fault_done
);
   import xlc_pkg::*;

   localparam int TAG_W = VA_W - PAGE_BITS;
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   if (ENTRIES < 2) begin : g_bad_entries
      $error("xlc_cache: ENTRIES must be at least 2");
   end
   if (PAGE_BITS <= PTE_WR_BIT || PAGE_BITS >= VA_W) begin : g_bad_page
      $error("xlc_cache: PAGE_BITS must exceed the permission bits and be below VA_W");
   end

   logic [ENTRIES-1:0] valid_vec;
   logic [TAG_W-1:0]   tag_arr  [ENTRIES];
   logic [TAG_W-1:0]   ppn_arr  [ENTRIES];
   xlc_perm_t          perm_arr [ENTRIES];

   logic [TAG_W-1:0] lk_vpn, zl_vpn;
   assign lk_vpn = lk_iova[VA_W-1:PAGE_BITS];
   assign zl_vpn = zap_line_iova[VA_W-1:PAGE_BITS];

   // Three parallel comparisons: lookup, fill and single-line shootdown
   logic [ENTRIES-1:0] lk_vec, fl_vec, zl_vec;
   logic               lk_any, fl_any, zl_any;
   logic [IDX_W-1:0]   lk_idx, fl_idx, zl_idx;

   xlc_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_lk_match (
      .valid(valid_vec), .tags(tag_arr), .key(lk_vpn),
      .hit_vec(lk_vec), .hit_any(lk_any), .hit_idx(lk_idx));

   xlc_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_fl_match (
      .valid(valid_vec), .tags(tag_arr), .key(fill_vpn),
      .hit_vec(fl_vec), .hit_any(fl_any), .hit_idx(fl_idx));

   xlc_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_zl_match (
      .valid(valid_vec), .tags(tag_arr), .key(zl_vpn),
      .hit_vec(zl_vec), .hit_any(zl_any), .hit_idx(zl_idx));

   // Round-robin victim, advanced only by a fresh allocation
   logic [IDX_W-1:0] vic_ptr;
   xlc_victim #(.ENTRIES(ENTRIES)) u_victim (
      .clk(clk), .rst_n(rst_n),
      .advance(fill_valid && !fl_any),
      .ptr(vic_ptr));

   logic kill_all, fill_kill;
   assign kill_all  = zap_all || fault_done;
   assign fill_kill = kill_all || (zap_line_valid && (zl_vpn == fill_vpn));

   xlc_perm_t fill_perm;
   assign fill_perm = '{rd: fill_pte[PTE_RD_BIT], wr: fill_pte[PTE_WR_BIT]};

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic             v_q;
      logic [TAG_W-1:0] t_q;
      logic [TAG_W-1:0] p_q;
      xlc_perm_t        a_q;
      logic             wr_sel;

      assign wr_sel = fill_valid &&
                      (fl_any ? fl_vec[e] : (vic_ptr == IDX_W'(e)));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            t_q <= '0;
            p_q <= '0;
            a_q <= '0;
         end else if (wr_sel) begin
            v_q <= !fill_kill;
            t_q <= fill_vpn;
            p_q <= fill_pte[VA_W-1:PAGE_BITS];
            a_q <= fill_perm;
         end else if (kill_all || (zap_line_valid && zl_vec[e])) begin
            v_q <= 1'b0;
         end
      end

      assign valid_vec[e] = v_q;
      assign tag_arr[e]   = t_q;
      assign ppn_arr[e]   = p_q;
      assign perm_arr[e]  = a_q;
   end

   // Lookup result: bypass when paging is off, else the hitting entry
   always_comb begin
      if (!paging_en) begin
         lk_hit   = lk_valid;
         lk_paddr = lk_iova;
         lk_rd_ok = 1'b1;
         lk_wr_ok = 1'b1;
      end else begin
         lk_hit   = lk_valid && lk_any;
         lk_paddr = {ppn_arr[lk_idx], lk_iova[PAGE_BITS-1:0]};
         lk_rd_ok = perm_arr[lk_idx].rd;
         lk_wr_ok = perm_arr[lk_idx].wr;
      end
   end

   assign fill_req     = lk_valid && paging_en && !lk_any;
   assign fill_req_vpn = lk_vpn;
endmodule

// File: rtl/xlc_cache_chk.sv
module xlc_cache_chk #(
   parameter int VA_W      = 32,
   parameter int PAGE_BITS = 12,
   parameter int ENTRIES   = 8
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      paging_en,
   input logic                      lk_valid,
   input logic [VA_W-1:0]           lk_iova,
   input logic                      lk_hit,
   input logic [VA_W-1:0]           lk_paddr,
   input logic                      lk_rd_ok,
   input logic                      lk_wr_ok,
   input logic                      fill_req,
   input logic [VA_W-PAGE_BITS-1:0] fill_req_vpn,
   input logic                      fill_valid,
   input logic [VA_W-PAGE_BITS-1:0] fill_vpn,
   input logic [VA_W-1:0]           fill_pte,
   input logic                      zap_line_valid,
   input logic [VA_W-1:0]           zap_line_iova,
   input logic                      zap_all,
   input logic                      fault_done
);
   logic clean_fill;
   assign clean_fill = fill_valid && !zap_all && !fault_done &&
                       !(zap_line_valid &&
                         zap_line_iova[VA_W-1:PAGE_BITS] == fill_vpn);

   // R2
   offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_hit && paging_en) |-> lk_paddr[PAGE_BITS-1:0] == lk_iova[PAGE_BITS-1:0]);

   // R3
   fill_then_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clean_fill |=> (!(lk_valid && paging_en &&
                        lk_iova[VA_W-1:PAGE_BITS] == $past(fill_vpn)) || lk_hit));

   // R3
   miss_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_req |-> (lk_valid && paging_en && !lk_hit &&
                    fill_req_vpn == lk_iova[VA_W-1:PAGE_BITS]));

   // R8
   zap_all_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      zap_all |=> !(paging_en && lk_hit));

   // R9
   fault_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_done |=> !(paging_en && lk_hit));

   // R10
   zap_beats_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid && zap_line_valid &&
       zap_line_iova[VA_W-1:PAGE_BITS] == fill_vpn)
      |=> !(paging_en && lk_valid && lk_hit &&
            lk_iova[VA_W-1:PAGE_BITS] == $past(fill_vpn)));

   // R11
   bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && !paging_en) |->
         (lk_hit && lk_paddr == lk_iova && lk_rd_ok && lk_wr_ok && !fill_req));
endmodule

bind xlc_cache xlc_cache_chk #(
   .VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .ENTRIES(ENTRIES)
) u_chk (.*);

// File: tb/xlc_cache_tb.sv
`timescale 1ns/1ps
module xlc_cache_tb;
   localparam int ENT = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        paging_en = 1'b1;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_iova = '0;
   logic        lk_hit, lk_rd_ok, lk_wr_ok, fill_req;
   logic [31:0] lk_paddr;
   logic [19:0] fill_req_vpn;
   logic        fill_valid = 1'b0;
   logic [19:0] fill_vpn = '0;
   logic [31:0] fill_pte = '0;
   logic        zap_line_valid = 1'b0;
   logic [31:0] zap_line_iova = '0;
   logic        zap_all = 1'b0;
   logic        fault_done = 1'b0;

   always #2.5 clk = ~clk;

   xlc_cache #(.VA_W(32), .PAGE_BITS(12), .ENTRIES(ENT)) u_dut (.*);

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   // Reference model of the entry array
   bit          m_v [ENT];
   logic [19:0] m_t [ENT];
   logic [31:0] m_p [ENT];
   int          m_ptr;

   function automatic int m_find(logic [19:0] t);
      for (int i = 0; i < ENT; i++) if (m_v[i] && m_t[i] == t) return i;
      return -1;
   endfunction

   function automatic logic [19:0] vpn_of(int k);
      return 20'h4A000 + 20'(k) * 20'h113;
   endfunction

   task automatic report(bit ok, string req, string act, string exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %s expected %s", req, act, exp);
      end
   endtask

   task automatic set_idle();
      fill_valid = 1'b0; zap_line_valid = 1'b0; zap_all = 1'b0; fault_done = 1'b0;
   endtask

   task automatic check_lookup(logic [31:0] iova, logic pg, string req);
      bit eh, ef, er, ew, ok;
      logic [31:0] ep;
      int idx;
      @(negedge clk);
      set_idle();
      paging_en = pg; lk_valid = 1'b1; lk_iova = iova;
      #1;
      er = 1'b1; ew = 1'b1; ep = iova; ef = 1'b0; eh = 1'b1;
      if (pg) begin
         idx = m_find(iova[31:12]);
         if (idx >= 0) begin
            ep = {m_p[idx][31:12], iova[11:0]};
            er = m_p[idx][1]; ew = m_p[idx][2];
         end else begin
            eh = 1'b0; ef = 1'b1;
         end
      end
      ok = (lk_hit == eh) && (fill_req == ef) &&
           (!eh || (lk_paddr == ep && lk_rd_ok == er && lk_wr_ok == ew)) &&
           (!ef || fill_req_vpn == iova[31:12]);
      report(ok, req,
         $sformatf("hit=%b pa=%h rd=%b wr=%b req=%b vpn=%h", lk_hit, lk_paddr, lk_rd_ok, lk_wr_ok, fill_req, fill_req_vpn),
         $sformatf("hit=%b pa=%h rd=%b wr=%b req=%b vpn=%h", eh, ep, er, ew, ef, iova[31:12]));
   endtask

   // One clock edge with the given strobes; the model follows the requirements
   task automatic do_op(bit fv, logic [19:0] ft, logic [31:0] fp,
                        bit zv, logic [31:0] zi, bit za, bit fd);
      int idx;
      @(negedge clk);
      fill_valid = fv; fill_vpn = ft; fill_pte = fp;
      zap_line_valid = zv; zap_line_iova = zi; zap_all = za; fault_done = fd;
      idx = -1;
      if (fv) begin
         idx = m_find(ft);
         if (idx < 0) begin
            idx = m_ptr;
            m_ptr = (m_ptr + 1) % ENT;
         end
      end
      for (int i = 0; i < ENT; i++) begin
         if (za || fd) m_v[i] = 1'b0;
         if (zv && m_v[i] && m_t[i] == zi[31:12]) m_v[i] = 1'b0;
      end
      if (fv) begin
         m_t[idx] = ft; m_p[idx] = fp;
         m_v[idx] = !(za || fd || (zv && zi[31:12] == ft));
      end
   endtask

   task automatic fill(logic [19:0] t, logic [31:0] p);
      do_op(1'b1, t, p, 1'b0, 32'h0, 1'b0, 1'b0);
   endtask

   function automatic logic [31:0] pte_of(int k, bit rd, bit wr);
      return {20'h80000 + 20'(k) * 20'h71, 9'h0, wr, rd, 1'b1};
   endfunction

   initial begin
      #(100000 * 5);
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < ENT; i++) begin m_v[i] = 1'b0; m_t[i] = '0; m_p[i] = '0; end
      m_ptr = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      report(!lk_hit && !fill_req, "R1", $sformatf("hit=%b req=%b", lk_hit, fill_req), "hit=0 req=0");

      // R1: empty after reset
      check_lookup({vpn_of(0), 12'h123}, 1'b1, "R1");
      // R3: miss is held with a request until the fill
      check_lookup({vpn_of(0), 12'h123}, 1'b1, "R3");
      check_lookup({vpn_of(0), 12'h123}, 1'b1, "R3");
      fill(vpn_of(0), pte_of(0, 1'b1, 1'b0));
      // R2, R4: hit with offset pass-through and read-only permissions
      check_lookup({vpn_of(0), 12'hFED}, 1'b1, "R2");
      // R11: bypass with paging off, then contents still present
      check_lookup(32'h1234_5678, 1'b0, "R11");
      check_lookup({vpn_of(0), 12'h001}, 1'b1, "R11");

      // R5: fill to capacity with mixed permissions
      for (int k = 1; k < ENT; k++) fill(vpn_of(k), pte_of(k, k[0], k[1]));
      for (int k = 0; k < ENT; k++) check_lookup({vpn_of(k), 12'h040}, 1'b1, "R4");
      // R6: refill page 1 in place, pointer stays on entry 0
      fill(vpn_of(1), pte_of(21, 1'b0, 1'b1));
      check_lookup({vpn_of(1), 12'h777}, 1'b1, "R6");
      fill(vpn_of(8), pte_of(8, 1'b1, 1'b1));
      check_lookup({vpn_of(0), 12'h000}, 1'b1, "R5");
      check_lookup({vpn_of(1), 12'h000}, 1'b1, "R6");
      check_lookup({vpn_of(8), 12'h000}, 1'b1, "R5");

      // R7: single-line shootdown with nonzero offset bits
      do_op(1'b0, '0, '0, 1'b1, {vpn_of(2), 12'hABC}, 1'b0, 1'b0);
      check_lookup({vpn_of(2), 12'h010}, 1'b1, "R7");
      check_lookup({vpn_of(3), 12'h010}, 1'b1, "R7");

      // R10: shootdown and fill of the same page in one cycle
      do_op(1'b1, vpn_of(2), pte_of(2, 1'b1, 1'b1), 1'b1, {vpn_of(2), 12'h005}, 1'b0, 1'b0);
      check_lookup({vpn_of(2), 12'h010}, 1'b1, "R10");
      // R10: flush together with a fill
      do_op(1'b1, vpn_of(9), pte_of(9, 1'b1, 1'b1), 1'b0, '0, 1'b1, 1'b0);
      check_lookup({vpn_of(9), 12'h010}, 1'b1, "R10");
      // R8: flush leaves nothing
      fill(vpn_of(4), pte_of(4, 1'b1, 1'b1));
      fill(vpn_of(5), pte_of(5, 1'b1, 1'b0));
      do_op(1'b0, '0, '0, 1'b0, '0, 1'b1, 1'b0);
      for (int k = 0; k < 10; k++) check_lookup({vpn_of(k), 12'h020}, 1'b1, "R8");
      // R9: fault retire flushes
      fill(vpn_of(6), pte_of(6, 1'b1, 1'b1));
      check_lookup({vpn_of(6), 12'h020}, 1'b1, "R9");
      do_op(1'b0, '0, '0, 1'b0, '0, 1'b0, 1'b1);
      check_lookup({vpn_of(6), 12'h020}, 1'b1, "R9");

      // Random phase over a small page pool
      for (int it = 0; it < 600; it++) begin
         int r;
         int k;
         r = $urandom_range(0, 99);
         k = $urandom_range(0, 11);
         if (r < 50)
            do_op(1'b1, vpn_of(k), pte_of($urandom_range(0, 60), 1'($urandom), 1'($urandom)),
                  ($urandom_range(0, 9) == 0), {vpn_of($urandom_range(0, 11)), 12'($urandom)},
                  1'b0, 1'b0);
         else if (r < 65)
            do_op(1'b0, '0, '0, 1'b1, {vpn_of(k), 12'($urandom)}, 1'b0, 1'b0);
         else if (r < 67)
            do_op(1'b0, '0, '0, 1'b0, '0, 1'b1, 1'b0);
         else if (r < 69)
            do_op(1'b0, '0, '0, 1'b0, '0, 1'b0, 1'b1);
         check_lookup({vpn_of($urandom_range(0, 11)), 12'($urandom)},
                      ($urandom_range(0, 19) != 0), "R5");
      end

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule